// File: doc/BRIEF.md
# Synchronized-Input SPI Slave Port

This block is an SPI slave that runs entirely on the system clock. The SCK, chip-select and MOSI pins each pass through a two-flop synchronizer. Edges of the synchronized SCK decide when MOSI is sampled and when the next MISO bit is launched. Because of this oversampling, SCK may run at up to one eighth of the system clock.

Software sees four byte-wide registers on a simple write-strobe bus with a combinational read port:

- **Control** (address 0): enable, master select, clock polarity, clock phase, interrupt enable, and a start-up interrupt trigger.
- **Format** (address 1): character length and the chip-select direction.
- **Data** (address 2): one register shared by transmit and receive.
- **Status** (address 3): write-1-to-clear flags and a busy bit.

Characters of 1 to 8 bits are shifted MSB first. A received character is written right-aligned into the data register, and the completion flag is set.

The block also reports three errors:

- a write to the data register during a character (overrun),
- a chip-select assertion while master mode is enabled (multimaster collision),
- chip-select released before the character is complete (abort).

Top module: `spi_slave`

## Requirements
- R1: After reset every register reads 0x00, `miso_oe` is 0 and `irq` is 0.
- R2: The port is a slave only when control bit0 (enable) is 1, control bit1 (master) is 0 and format bit3 (select direction) is 0. `miso_oe` is 1 only while it is a slave and the synchronized `ss_n` is low.
- R3: Format bits[2:0] give the character length, and the code 0 means 8 bits. A received character is written to the data register right-aligned, with the unused upper bits cleared.
- R4: MISO sends the data register MSB first, starting with bit (length-1). If software has not written the data register, the value it already holds (for example the last received character) is sent.
- R5: Control bit2 (CPOL) gives the SCK idle level. With control bit3 (CPHA) = 0, MOSI is sampled on the leading edge and MISO changes on the trailing edge. With CPHA = 1, MISO changes on the leading edge and MOSI is sampled on the trailing edge.
- R6: When a full character completes, status bit0 (interrupt flag) is set and status bit4 (busy) returns to 0. The `irq` output equals the interrupt flag ANDed with control bit4 (interrupt enable).
- R7: A write to the data register while a character is in progress sets status bit1 (overrun) and leaves the data register unchanged.
- R8: A falling edge of the synchronized `ss_n` while enable and master are both 1 sets status bit2 (collision). In slave mode it does not set this bit.
- R9: If `ss_n` rises during a character, status bit3 (abort) and status bit0 are set. The partial character is discarded, and the next character starts from bit 0.
- R10: Writing control with bit5 (start) set sets status bit0. Bit5 is not stored and always reads as 0.
- R11: Writing 1 to any of status bits[3:0] clears that flag. Writing 0 to a flag leaves it unchanged.
- R12: All of the above hold when SCK has a period of 8 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on `bus_addr`) |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | MISO output enable |
| irq | output | 1 | Interrupt request |

## Verification
If the bit counter goes wrong, a received byte shows up rotated or truncated in the data register at the end of that character. It can also show up as a spurious abort or a missing completion flag once `ss_n` rises, a few clocks later. A wrong transmit shift register shows up on MISO at the master's very next sampling edge. A misplaced sampling edge between the two phase settings corrupts every byte in that mode, so each polarity and phase combination is run with asymmetric patterns. Error flags that are wrongly held or wrongly cleared show up in the next status read after the event.

// File: rtl/spi_slave.sv
`timescale 1ns/1ps
module spi_slave (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sck,
  input  logic       ss_n,
  input  logic       mosi,
  output logic       miso,
  output logic       miso_oe,
  output logic       irq
);
  localparam logic [1:0] A_CTRL = 2'd0, A_FMT = 2'd1, A_DATA = 2'd2, A_STAT = 2'd3;

  logic       en, mst, cpol, cpha, ie, ssdir;
  logic [2:0] len;
  logic [7:0] data_q, txsh, rxsh;
  logic [2:0] cnt;
  logic       act;
  logic       f_irq, f_ovr, f_col, f_abt;
  logic [1:0] sck_p, ss_p, mosi_p;
  logic       sck_q, ss_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0; ss_p <= 2'b11; mosi_p <= '0; sck_q <= 1'b0; ss_q <= 1'b1;
    end else begin
      sck_p  <= {sck_p[0], sck};
      ss_p   <= {ss_p[0], ss_n};
      mosi_p <= {mosi_p[0], mosi};
      sck_q  <= sck_p[1];
      ss_q   <= ss_p[1];
    end

  wire sck_s   = sck_p[1];
  wire ss_s    = ss_p[1];
  wire mosi_s  = mosi_p[1];
  wire slave   = en & ~mst & ~ssdir;
  wire sel     = slave & ~ss_s;
  wire rise    = sck_s & ~sck_q;
  wire fall    = ~sck_s & sck_q;
  wire lead    = cpol ? fall : rise;
  wire trail   = cpol ? rise : fall;
  wire samp_e  = sel & (cpha ? trail : lead);
  wire launch_e = sel & (cpha ? lead : trail);
  wire ss_rise = ss_s & ~ss_q;
  wire ss_fall = ~ss_s & ss_q;

  wire [3:0] nlen  = (len == 3'd0) ? 4'd8 : {1'b0, len};
  wire [2:0] last  = len - 3'd1;
  wire [7:0] mask  = 8'hFF >> (4'd8 - nlen);
  wire [7:0] rx_nx = {rxsh[6:0], mosi_s};
  wire       done  = samp_e & (cnt == last);
  wire       abort = slave & ss_rise & act;
  wire       wr_ctrl = bus_wr & (bus_addr == A_CTRL);
  wire       wr_fmt  = bus_wr & (bus_addr == A_FMT);
  wire       wr_data = bus_wr & (bus_addr == A_DATA);
  wire       wr_stat = bus_wr & (bus_addr == A_STAT);
  wire       col_evt = en & mst & ss_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {en, mst, cpol, cpha, ie} <= '0;
      len <= '0; ssdir <= 1'b0;
    end else begin
      if (wr_ctrl) {ie, cpha, cpol, mst, en} <= bus_wdata[4:0];
      if (wr_fmt) {ssdir, len} <= bus_wdata[3:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act <= 1'b0; cnt <= '0; rxsh <= '0; txsh <= '0; data_q <= '0;
    end else begin
      if (!sel || done) begin
        act <= 1'b0; cnt <= '0; rxsh <= '0;
      end else if (samp_e) begin
        act <= 1'b1; cnt <= cnt + 3'd1; rxsh <= rx_nx;
      end else if (launch_e && cpha) begin
        act <= 1'b1;
      end
      if (!act) txsh <= data_q;
      else if (launch_e && cnt != 3'd0) txsh <= {txsh[6:0], 1'b0};
      if (done) data_q <= rx_nx & mask;
      else if (wr_data && !act) data_q <= bus_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {f_irq, f_ovr, f_col, f_abt} <= '0;
    end else begin
      f_irq <= done | abort | (wr_ctrl & bus_wdata[5]) | (f_irq & ~(wr_stat & bus_wdata[0]));
      f_ovr <= (wr_data & act) | (f_ovr & ~(wr_stat & bus_wdata[1]));
      f_col <= col_evt | (f_col & ~(wr_stat & bus_wdata[2]));
      f_abt <= abort | (f_abt & ~(wr_stat & bus_wdata[3]));
    end

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = {3'b000, ie, cpha, cpol, mst, en};
      A_FMT:   bus_rdata = {4'b0000, ssdir, len};
      A_DATA:  bus_rdata = data_q;
      default: bus_rdata = {3'b000, act, f_abt, f_col, f_ovr, f_irq};
    endcase

  assign miso    = txsh[last];
  assign miso_oe = sel;
  assign irq     = f_irq & ie;
endmodule

module spi_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_data,
  input logic       act,
  input logic       done,
  input logic       abort,
  input logic       col_evt,
  input logic       ss_rise,
  input logic [2:0] cnt,
  input logic [3:0] nlen,
  input logic [7:0] data_q,
  input logic       f_irq,
  input logic       f_ovr,
  input logic       f_col,
  input logic       f_abt
);
  // R7
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && act && !done) |=> (f_ovr && data_q == $past(data_q)));
  // R9
  abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (f_abt && f_irq && !act && cnt == 3'd0));
  // R8
  col_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_evt |=> f_col);
  // R6
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (f_irq && !act));
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} < nlen);
  // R9
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_rise |=> !act);
endmodule

bind spi_slave spi_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .act(act), .done(done),
  .abort(abort), .col_evt(col_evt), .ss_rise(ss_rise), .cnt(cnt), .nlen(nlen),
  .data_q(data_q), .f_irq(f_irq), .f_ovr(f_ovr), .f_col(f_col), .f_abt(f_abt)
);

// File: tb/spi_slave_tb.sv
`timescale 1ns/1ps
module spi_slave_tb;
  localparam int H = 4;
  localparam logic [20:0] VEC [0:6] = '{
    {1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 3'd0, 8'h81, 8'h7E},
    {1'b1, 1'b0, 3'd0, 8'hC3, 8'h5A},
    {1'b1, 1'b1, 3'd0, 8'h0F, 8'hF0},
    {1'b0, 1'b0, 3'd5, 8'h17, 8'h0B},
    {1'b1, 1'b1, 3'd3, 8'h05, 8'h06},
    {1'b1, 1'b0, 3'd7, 8'h55, 8'h2A}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, irq;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spi_slave u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .ss_n(ss_n),
    .mosi(mosi), .miso(miso), .miso_oe(miso_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic xfer(input bit pol, input bit pha, input int n, input int nclk,
                      input logic [7:0] mo, input bit wmid, output logic [7:0] mi);
    mi = '0;
    sck = pol;
    repeat (H) @(negedge clk);
    ss_n = 1'b0;
    repeat (2*H) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      if (!pha) begin
        mosi = mo[n-1-i];
        repeat (H) @(negedge clk);
        mi = {mi[6:0], miso}; sck = ~sck;
        repeat (H) @(negedge clk);
        sck = ~sck;
      end else begin
        repeat (H) @(negedge clk);
        sck = ~sck; mosi = mo[n-1-i];
        repeat (H) @(negedge clk);
        mi = {mi[6:0], miso}; sck = ~sck;
      end
      if (wmid && i == 1) wr(2'd2, 8'hFF);
    end
    repeat (H) @(negedge clk);
    ss_n = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  function automatic logic [7:0] msk(input int n);
    return (n == 8) ? 8'hFF : 8'((9'd1 << n) - 9'd1);
  endfunction

  initial begin
    #1200000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 00 expected 01");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, mi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); check("R1 reg", v, 8'h00);
    end
    check("R1 oe", {7'b0, miso_oe}, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);

    // main table: R3 R4 R5 R6 R12
    for (int k = 0; k < 7; k++) begin
      bit pol, pha; logic [2:0] lf; logic [7:0] tx, mo; int n;
      {pol, pha, lf, tx, mo} = VEC[k];
      n = (lf == 3'd0) ? 8 : int'(lf);
      wr(2'd0, {3'b000, 1'b1, pha, pol, 1'b0, 1'b1});
      wr(2'd1, {5'b0, lf});
      wr(2'd2, tx);
      wr(2'd3, 8'h0F);
      xfer(pol, pha, n, n, mo, 1'b0, mi);
      rd(2'd2, v); check("R3 rx", v, mo & msk(n));
      check("R4 R5 tx", mi & msk(n), tx & msk(n));
      rd(2'd3, v); check("R6 stat", v, 8'h01);
      check("R6 irq", {7'b0, irq}, 8'h01);
    end

    // R4 unwritten data register is resent
    wr(2'd0, 8'h11); wr(2'd1, 8'h00); wr(2'd2, 8'hA5);
    xfer(1'b0, 1'b0, 8, 8, 8'h66, 1'b0, mi);
    xfer(1'b0, 1'b0, 8, 8, 8'h11, 1'b0, mi);
    check("R4 resend", mi, 8'h66);
    rd(2'd2, v); check("R4 rx", v, 8'h11);

    // R7 R9 abort with overrun write
    wr(2'd2, 8'h3C); wr(2'd3, 8'h0F);
    xfer(1'b0, 1'b0, 8, 3, 8'hC9, 1'b1, mi);
    rd(2'd3, v); check("R7 R9 stat", v, 8'h0B);
    rd(2'd2, v); check("R7 R9 data", v, 8'h3C);
    // R11 partial clear
    wr(2'd3, 8'h02);
    rd(2'd3, v); check("R11 ovr clr", v, 8'h09);
    wr(2'd3, 8'h09);
    rd(2'd3, v); check("R11 all clr", v, 8'h00);
    // R9 fresh character after abort
    xfer(1'b0, 1'b0, 8, 8, 8'h96, 1'b0, mi);
    rd(2'd2, v); check("R9 rx", v, 8'h96);
    check("R9 tx", mi, 8'h3C);

    // R2 slave selection
    wr(2'd0, 8'h03); ss_n = 1'b0; repeat (6) @(negedge clk);
    check("R2 master oe", {7'b0, miso_oe}, 8'h00);
    rd(2'd3, v); check("R8 col", v & 8'h04, 8'h04);
    ss_n = 1'b1; repeat (6) @(negedge clk);
    wr(2'd3, 8'h04);
    rd(2'd3, v); check("R11 col clr", v & 8'h04, 8'h00);
    wr(2'd0, 8'h01); wr(2'd1, 8'h08);
    ss_n = 1'b0; repeat (6) @(negedge clk);
    check("R2 ssdir oe", {7'b0, miso_oe}, 8'h00);
    ss_n = 1'b1; repeat (6) @(negedge clk);
    wr(2'd1, 8'h00);
    ss_n = 1'b0; repeat (6) @(negedge clk);
    check("R2 slave oe", {7'b0, miso_oe}, 8'h01);
    rd(2'd3, v); check("R8 no col", v & 8'h04, 8'h00);
    ss_n = 1'b1; repeat (6) @(negedge clk);
    check("R2 release oe", {7'b0, miso_oe}, 8'h00);

    // R10 start bit, R6 enable gating
    wr(2'd3, 8'h0F);
    wr(2'd0, 8'h31);
    rd(2'd3, v); check("R10 stat", v, 8'h01);
    check("R10 irq", {7'b0, irq}, 8'h01);
    rd(2'd0, v); check("R10 ctrl", v, 8'h11);
    wr(2'd0, 8'h01);
    check("R6 masked irq", {7'b0, irq}, 8'h00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule